// File: doc/BRIEF.md
# Limit-Compare Interval Counter

This block is a system interval timer behind a small word-addressed register port. A prescaler turns the system clock into a one-cycle tick every 500 ns. On each tick a count field moves up by one step. The count sits in the upper part of a 32-bit word, and the least significant step is bit 9. The nine bits below it always read as zero.

Software programs a limit. When the count is about to equal a nonzero limit, the count returns to zero on that same tick. At the same moment a sticky reached flag sets and a level interrupt rises, so the block fires once every "limit" ticks. A limit of zero puts the block in free-running mode: the count wraps at its maximum and never signals anything.

The reached flag appears in bit 31 of the count word. Reading the limit register clears both the flag and the interrupt. A second write address changes the limit without disturbing the running count.

Top module: `lcmp_interval_timer`

## Requirements
- R1: After reset the stored limit, the count and the reached flag are zero, `irq` is low, and the block is in free-running mode. Reads of offsets 0 and 1 return zero while reset is held.
- R2: The count field occupies bits [LSB_POS+CNT_BITS-1:LSB_POS], which is [30:9] by default. It advances by one on each tick. Bits below LSB_POS always read zero. The first tick comes TICK_CYCLES clocks after a restart, and later ticks follow every TICK_CYCLES clocks. TICK_CYCLES is CLK_KHZ*TICK_NS/10^6, rounded, and never less than 2.
- R3: With a nonzero limit, a tick on which the count would reach the limit loads zero into the count, sets the reached flag and raises `irq`. The block therefore signals once every "limit" ticks.
- R4: With a limit of zero the count wraps from its all-ones value to zero. The reached flag never sets and `irq` never rises.
- R5: A write to offset 0 stores the data ANDed with the field mask (0x7FFFFE00 by default). It restarts the count and the prescaler phase from zero and lowers `irq`. The reached flag is left unchanged.
- R6: A write to offset 2 stores the masked limit but leaves the count, the prescaler phase, `irq` and the reached flag unchanged.
- R7: A read of offset 0 returns the stored limit with bit 31 at zero, and clears the reached flag and `irq` at the clock edge. A match on that same edge takes priority, so the flag and `irq` end up set.
- R8: A read of offset 1 returns the count field with the reached flag in bit 31.
- R9: Writes to offset 1 and to offsets 3 and above have no effect. Reads of offsets 3 and above return zero.
- R10: `irq` is a level output. It is high only while the reached flag is set, and it stays high until a limit read or a limit write lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as a read request |
| irq | output | 1 | Level interrupt, raised by a limit match |

## Verification
On every cycle the assertions check these invariants:
- `irq` implies the reached flag.
- `irq` only rises out of a nonzero limit.
- A limit write restarts the count and lowers the interrupt.
- A limit read without a coincident match clears the flag.
- The count holds between ticks.
- Ticks are never back to back.
- The low bits of the count word and unmapped reads are zero.

The directed scenarios show what the assertions cannot:
- The exact period and the reload to zero.
- The wrap in free-running mode.
- The limit-without-restart write taking effect at the new limit.
- The priority of a match over a same-cycle limit read.
- The full-scale limit.

// File: rtl/lcit_pkg.sv
package lcit_pkg;

    // Word offsets of the register port
    localparam int unsigned OFS_LIMIT      = 0;
    localparam int unsigned OFS_COUNT      = 1;
    localparam int unsigned OFS_LIMIT_KEEP = 2;

    // Register state held at the top level
    typedef struct packed {
        logic [31:0] limit;     // masked limit word
        logic        reached;   // sticky match flag
        logic        irq;       // interrupt level
    } lcit_state_t;

endpackage

// File: rtl/lcit_prescaler.sv
module lcit_prescaler #(
    parameter int unsigned TICK_CYCLES = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = $clog2(TICK_CYCLES);
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        tick    = (phase_q == LAST);
        phase_d = tick ? '0 : phase_q + 1'b1;
        if (restart) begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/lcit_counter.sv
module lcit_counter #(
    parameter int unsigned CNT_BITS = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                tick,
    input  logic [CNT_BITS-1:0] limit_units,
    output logic [CNT_BITS-1:0] units_q,
    output logic                hit
);
    logic [CNT_BITS-1:0] units_d;
    logic [CNT_BITS-1:0] step;
    logic                match;

    always_comb begin
        step    = units_q + 1'b1;          // wraps naturally in free-run
        match   = (limit_units != '0) && (step == limit_units);
        hit     = tick && match && !clear;
        units_d = units_q;
        if (clear) begin
            units_d = '0;
        end else if (tick) begin
            units_d = match ? '0 : step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units_q <= '0;
        end else begin
            units_q <= units_d;
        end
    end
endmodule

// File: rtl/lcmp_interval_timer.sv
module lcmp_interval_timer #(
    parameter int unsigned CLK_KHZ  = 125000,
    parameter int unsigned TICK_NS  = 500,
    parameter int unsigned CNT_BITS = 22,
    parameter int unsigned LSB_POS  = 9,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              irq
);
    import lcit_pkg::*;

    localparam int unsigned RAW_CYCLES  = (CLK_KHZ * TICK_NS + 500000) / 1000000;
    localparam int unsigned TICK_CYCLES = (RAW_CYCLES < 2) ? 2 : RAW_CYCLES;
    localparam logic [31:0] FIELD_MASK  =
        32'(((64'd1 << CNT_BITS) - 64'd1) << LSB_POS);

    lcit_state_t st_d, st_q;

    logic                tick;
    logic                hit;
    logic [CNT_BITS-1:0] units_q;
    logic                rd_en, wr_en;
    logic                rd_lim, wr_lim, wr_keep;
    logic [31:0]         count_word;

    always_comb begin
        rd_en   = req_valid && !req_write;
        wr_en   = req_valid && req_write;
        rd_lim  = rd_en && (req_addr == ADDR_W'(OFS_LIMIT));
        wr_lim  = wr_en && (req_addr == ADDR_W'(OFS_LIMIT));
        wr_keep = wr_en && (req_addr == ADDR_W'(OFS_LIMIT_KEEP));
    end

    lcit_prescaler #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(wr_lim),
        .tick   (tick)
    );

    lcit_counter #(
        .CNT_BITS(CNT_BITS)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (wr_lim),
        .tick       (tick),
        .limit_units(st_q.limit[LSB_POS +: CNT_BITS]),
        .units_q    (units_q),
        .hit        (hit)
    );

    // Next-state of the register set
    always_comb begin
        st_d = st_q;
        if (wr_lim || wr_keep) begin
            st_d.limit = req_wdata & FIELD_MASK;
        end
        if (rd_lim) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
        if (wr_lim) begin
            st_d.irq = 1'b0;
        end
        if (hit) begin                      // a match outranks the read clear
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end
    end

    // Read path, combinational in the request cycle
    always_comb begin
        count_word                         = '0;
        count_word[LSB_POS +: CNT_BITS]    = units_q;
        count_word[31]                     = st_q.reached;
        rd_data = '0;
        if (rd_en) begin
            if (req_addr == ADDR_W'(OFS_LIMIT)) begin
                rd_data = {1'b0, st_q.limit[30:0]};
            end else if (req_addr == ADDR_W'(OFS_COUNT)) begin
                rd_data = count_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/lcit_checker.sv
module lcit_checker #(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned CNT_BITS    = 22,
    parameter int unsigned LSB_POS     = 9,
    parameter int unsigned TICK_CYCLES = 63
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [31:0]         rd_data,
    input logic                irq,
    input logic                tick,
    input logic                hit,
    input logic [CNT_BITS-1:0] units_q,
    input logic [31:0]         limit_q,
    input logic                reached_q
);
    localparam logic [31:0] LOW_MASK = 32'((64'd1 << LSB_POS) - 64'd1);

    logic rd_lim, wr_lim, wr_keep, rd_cnt, rd_hole;
    assign rd_lim  = req_valid && !req_write && (req_addr == ADDR_W'(0));
    assign wr_lim  = req_valid &&  req_write && (req_addr == ADDR_W'(0));
    assign wr_keep = req_valid &&  req_write && (req_addr == ADDR_W'(2));
    assign rd_cnt  = req_valid && !req_write && (req_addr == ADDR_W'(1));
    assign rd_hole = req_valid && !req_write && (req_addr >= ADDR_W'(3));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reached_q);

    a_r4_no_irq_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(limit_q) != 32'd0));

    a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (reached_q && irq));

    a_r5_limit_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim |=> (!irq && units_q == '0));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !hit) |=> !reached_q);

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lim) |=> $stable(units_q));

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt |-> ((rd_data & LOW_MASK) == 32'd0));

    a_r6_keep_write_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_keep && !hit) |=> (irq == $past(irq)));

    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hole |-> (rd_data == 32'd0));
endmodule

bind lcmp_interval_timer lcit_checker #(
    .ADDR_W     (ADDR_W),
    .CNT_BITS   (CNT_BITS),
    .LSB_POS    (LSB_POS),
    .TICK_CYCLES(TICK_CYCLES)
) u_lcit_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rd_data  (rd_data),
    .irq      (irq),
    .tick     (tick),
    .hit      (hit),
    .units_q  (units_q),
    .limit_q  (st_q.limit),
    .reached_q(st_q.reached)
);

// File: tb/lcmp_interval_timer_bench.sv
module lcmp_interval_timer_bench;
    // 8000 kHz -> 4 clocks per tick; 6-bit count field at bit 9 (max 0x7E00)
    localparam int unsigned ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lcmp_interval_timer #(
        .CLK_KHZ (8000),
        .TICK_NS (500),
        .CNT_BITS(6),
        .LSB_POS (9),
        .ADDR_W  (ADDR_W)
    ) u_lcmp_interval_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    function automatic logic [31:0] u(input int k);
        return 32'(k) << 9;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start just after a falling edge; each access spans one rising edge.
    task automatic bus_wr(input int a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
        #1 d = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd0;
        #1 v = rd_data; check("R1 limit in reset", v, 32'd0);
        req_addr = 3'd1;
        #1 v = rd_data; check("R1 count in reset", v, 32'd0);
        check("R1 irq in reset", 32'(irq), 32'd0);
        req_valid = 1'b0;
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        bus_wr(0, 32'h8000_0A55);                          // n=0, limit 5 ticks
        bus_rd(0, v); check("R5 masked limit", v, 32'h0000_0A00);   // n=1
        edges(18);                                          // n=19
        check("R3 no irq before match", 32'(irq), 32'd0);
        bus_rd(1, v); check("R2 count step", v, u(4));      // n=20
        check("R3 irq at match", 32'(irq), 32'd1);
        bus_rd(1, v); check("R8 reload with flag", v, 32'h8000_0000); // n=21
        edges(3);                                           // n=24
        bus_rd(1, v); check("R3 flag sticky", v, 32'h8000_0000 | u(1)); // n=25
        bus_rd(0, v); check("R7 limit read", v, 32'h0000_0A00);      // n=26
        check("R7 irq cleared", 32'(irq), 32'd0);
        bus_rd(1, v); check("R7 flag cleared", v, u(1));    // n=27
        edges(13);                                          // n=40
        check("R3 second period", 32'(irq), 32'd1);
    endtask

    task automatic t_limit_write_keeps_flag;
        logic [31:0] v;
        bus_wr(0, u(3));
        check("R5 irq lowered", 32'(irq), 32'd0);
        bus_rd(1, v); check("R5 restart keeps flag", v, 32'h8000_0000);
    endtask

    task automatic t_keep_write;
        logic [31:0] v;
        bus_wr(0, 32'd0);                                   // n=0
        bus_rd(0, v); check("R7 zero limit read", v, 32'd0); // n=1
        edges(39);                                          // n=40, count 10
        bus_wr(2, u(12));                                   // n=41
        bus_rd(1, v); check("R6 count undisturbed", v, u(10)); // n=42
        edges(5);                                           // n=47
        check("R6 no irq yet", 32'(irq), 32'd0);
        bus_rd(1, v); check("R6 count runs on", v, u(11));  // n=48
        check("R6 new limit matched", 32'(irq), 32'd1);
        bus_rd(1, v); check("R6 reload", v, 32'h8000_0000);
    endtask

    task automatic t_freerun;
        logic [31:0] v;
        bus_wr(0, 32'h0000_01FF);                           // masks to 0: free-run
        bus_rd(0, v); check("R4 limit zero", v, 32'd0);     // n=1
        edges(251);                                         // n=252
        bus_rd(1, v); check("R4 count at max", v, 32'h0000_7E00); // n=253
        edges(3);                                           // n=256
        check("R4 no irq on wrap", 32'(irq), 32'd0);
        bus_rd(1, v); check("R4 wrap to zero no flag", v, 32'd0);
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        bus_wr(0, 32'd0);                                   // n=0
        edges(8);                                           // n=8
        bus_wr(1, 32'h1234_5600);                           // n=9
        bus_rd(1, v); check("R9 count write ignored", v, u(2)); // n=10
        bus_wr(5, 32'h7FFF_FFFF);
        bus_rd(5, v); check("R9 hole 5 reads zero", v, 32'd0);
        bus_rd(3, v); check("R9 hole 3 reads zero", v, 32'd0);
        bus_rd(7, v); check("R9 hole 7 reads zero", v, 32'd0);
        bus_rd(0, v); check("R9 limit untouched", v, 32'd0);
        check("R9 no irq", 32'(irq), 32'd0);
    endtask

    task automatic t_read_match_race;
        logic [31:0] v;
        bus_wr(0, u(2));                                    // n=0, match at n=8
        edges(7);                                           // n=7
        bus_rd(0, v); check("R7 read before match", v, u(2)); // n=8 (match edge)
        check("R7 match wins irq", 32'(irq), 32'd1);
        bus_rd(1, v); check("R7 match wins flag", v, 32'h8000_0000);
    endtask

    task automatic t_full_scale;
        logic [31:0] v;
        bus_wr(0, 32'hFFFF_FFFF);
        bus_rd(0, v); check("R5 full-scale limit", v, 32'h0000_7E00); // n=1
        edges(250);                                         // n=251
        check("R10 irq low before match", 32'(irq), 32'd0);
        edges(1);                                           // n=252
        check("R10 irq level at match", 32'(irq), 32'd1);
        bus_rd(1, v); check("R3 full-scale reload", v, 32'h8000_0000);
        edges(4);
        check("R10 irq held", 32'(irq), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        edges(2);
        rst_n = 1'b1;
        edges(1);
        t_periodic();
        t_limit_write_keeps_flag();
        t_keep_write();
        t_freerun();
        t_ignored();
        t_read_match_race();
        t_full_scale();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule